// File: doc/BRIEF.md
# Double-Sampling Row Readout Sequencer

This block produces the control strobes for reading one pixel row with correlated double sampling. A start pulse begins the sequence. The block first selects the requested row. It then samples the illuminated level of every column in parallel, with the far plate of each column capacitor held at ground. Next it resets the row while that plate floats, and samples the reset level. After both samples are held, it walks the stored per-column differences out through the output buffer, one column at a time, using two alternating output phases per column. A one-cycle done pulse marks the end of the last column.

The sampling capacitors, the column amplifier and the converter are not part of this block. They appear only as the strobes they would receive. Every phase lasts a programmable number of clock cycles, so the analog settling time can be tuned. The row index, column count and phase length are captured when a sequence starts.

Top module: `rowseq_top`

## Requirements
- R1: After reset, every strobe, `busy_o` and `done_o` are low until a start is accepted.
- R2: A start accepted while idle is followed by four phases in this order, each lasting the phase length in cycles: select only, signal sample (`samp_sig_o`), row reset (`row_rst_o`), reset sample (`samp_rst_o`). The first phase begins in the cycle after the start is sampled.
- R3: `row_sel_o` is one-hot with bit r set for captured row r. It is high throughout the select phase, the signal sample, the row reset and the reset sample, and it is low during the column scan.
- R4: `plate_gnd_o` is high exactly during the signal-sample phase. It is low (plate floating) during the row reset and in every other phase.
- R5: After the reset sample, for each column c from 0 up to the column count minus 1, `col_strb_o` has only bit c set. During that column, `rd_ph_a_o` is high for one phase length and then `rd_ph_b_o` is high for one phase length.
- R6: `done_o` is high for exactly one cycle, the cycle after the last column's second output phase. In that cycle `busy_o` and all strobes are low.
- R7: A start arriving while a sequence runs is ignored, as are changes to the row index, column count or phase length during a sequence. The running sequence completes unchanged and no second sequence follows.
- R8: A column count of 0 is used as 1, and a count above the column number is used as the column number. A phase length of 0 is used as 1.
- R9: Reset asserted during a sequence returns all outputs to their idle values at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when idle |
| row_idx_i | input | ROW_W (4) | Row to read |
| col_count_i | input | CNT_W (5) | Number of columns to scan |
| phase_len_i | input | PH_W (4) | Cycles per phase |
| row_sel_o | output | NUM_ROWS (16) | One-hot row select |
| row_rst_o | output | 1 | Row reset strobe |
| samp_sig_o | output | 1 | Illuminated-level sample strobe |
| samp_rst_o | output | 1 | Reset-level sample strobe |
| plate_gnd_o | output | 1 | Column capacitor far plate to ground |
| col_strb_o | output | NUM_COLS (16) | One-hot column readout strobe |
| rd_ph_a_o | output | 1 | First output phase of a column |
| rd_ph_b_o | output | 1 | Second output phase of a column |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-row pulse |

## Verification
The bench compares every output in every cycle against a model built from the phase length and column count. A phase counter off by one would stretch or shorten each phase and shift every later strobe. A scan that stopped early or ran one column too far would show up in the runs with one column, full width and clamped counts. A zero phase length that was not forced to one would wrap the counter and stall for many cycles. Starts and row changes injected mid-sequence would expose a design that restarts or re-latches its inputs. A reset during the scan would catch strobes left stuck high.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SAMP_SIG,
        ST_ROW_RST,
        ST_SAMP_RST,
        ST_READ_A,
        ST_READ_B
    } seq_state_e;
endpackage

// File: rtl/rowseq_phase_timer.sv
module rowseq_phase_timer #(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic [PH_W-1:0] len_i,
    output logic            last_o
);
    localparam logic [PH_W-1:0] ONE = PH_W'(1);

    logic [PH_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr_i ? '0 : cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == (len_i - ONE));
endmodule

// File: rtl/rowseq_col_scan.sv
module rowseq_col_scan #(
    parameter int NUM_COLS = 16,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic                clear_i,
    input  logic [CNT_W-1:0]    ncols_i,
    output logic [NUM_COLS-1:0] strb_o,
    output logic                last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [NUM_COLS-1:0] hot;
        logic [CNT_W-1:0]    idx;
    } scan_regs_t;

    scan_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d.hot = '0;
            s_d.idx = '0;
        end else if (load_i) begin
            s_d.hot = NUM_COLS'(1);
            s_d.idx = '0;
        end else if (step_i) begin
            s_d.hot = s_q.hot << 1;
            s_d.idx = s_q.idx + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strb_o = s_q.hot;
    assign last_o = (s_q.idx == (ncols_i - ONE));
endmodule

// File: rtl/rowseq_row_decode.sv
module rowseq_row_decode #(
    parameter int NUM_ROWS = 16,
    parameter int ROW_W    = 4
) (
    input  logic                en_i,
    input  logic [ROW_W-1:0]    row_i,
    output logic [NUM_ROWS-1:0] sel_o
);
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign sel_o[r] = en_i && (row_i == ROW_W'(r));
    end
endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
    import rowseq_pkg::*;
#(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 16,
    parameter int PH_W     = 4,
    localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1,
    localparam int CNT_W   = $clog2(NUM_COLS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ROW_W-1:0]    row_idx_i,
    input  logic [CNT_W-1:0]    col_count_i,
    input  logic [PH_W-1:0]     phase_len_i,
    output logic [NUM_ROWS-1:0] row_sel_o,
    output logic                row_rst_o,
    output logic                samp_sig_o,
    output logic                samp_rst_o,
    output logic                plate_gnd_o,
    output logic [NUM_COLS-1:0] col_strb_o,
    output logic                rd_ph_a_o,
    output logic                rd_ph_b_o,
    output logic                busy_o,
    output logic                done_o
);
    localparam logic [CNT_W-1:0] COL_MAX = CNT_W'(NUM_COLS);

    typedef struct packed {
        seq_state_e       state;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] ncols;
        logic [PH_W-1:0]  len;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             t_last, t_clr;
    logic             scan_load, scan_step, scan_clear, scan_last;
    logic [CNT_W-1:0] ncols_fix;
    logic [PH_W-1:0]  len_fix;
    logic             row_en;

    // Clamp the requested column count and phase length before capture.
    always_comb begin
        if (col_count_i == '0)         ncols_fix = CNT_W'(1);
        else if (col_count_i > COL_MAX) ncols_fix = COL_MAX;
        else                            ncols_fix = col_count_i;
        len_fix = (phase_len_i == '0) ? PH_W'(1) : phase_len_i;
    end

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        scan_load  = 1'b0;
        scan_step  = 1'b0;
        scan_clear = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_SELECT;
                    r_d.row   = row_idx_i;
                    r_d.ncols = ncols_fix;
                    r_d.len   = len_fix;
                end
            end
            ST_SELECT:   if (t_last) r_d.state = ST_SAMP_SIG;
            ST_SAMP_SIG: if (t_last) r_d.state = ST_ROW_RST;
            ST_ROW_RST:  if (t_last) r_d.state = ST_SAMP_RST;
            ST_SAMP_RST: begin
                if (t_last) begin
                    r_d.state = ST_READ_A;
                    scan_load = 1'b1;
                end
            end
            ST_READ_A:   if (t_last) r_d.state = ST_READ_B;
            ST_READ_B: begin
                if (t_last) begin
                    if (scan_last) begin
                        r_d.state  = ST_IDLE;
                        r_d.done   = 1'b1;
                        scan_clear = 1'b1;
                    end else begin
                        r_d.state = ST_READ_A;
                        scan_step = 1'b1;
                    end
                end
            end
            default: begin
                r_d.state  = ST_IDLE;
                scan_clear = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.ncols <= CNT_W'(1);
            r_q.len   <= PH_W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign t_clr = (r_q.state == ST_IDLE) || t_last;

    rowseq_phase_timer #(.PH_W(PH_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (t_clr),
        .len_i  (r_q.len),
        .last_o (t_last)
    );

    rowseq_col_scan #(.NUM_COLS(NUM_COLS), .CNT_W(CNT_W)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (scan_load),
        .step_i  (scan_step),
        .clear_i (scan_clear),
        .ncols_i (r_q.ncols),
        .strb_o  (col_strb_o),
        .last_o  (scan_last)
    );

    assign row_en = (r_q.state == ST_SELECT)   || (r_q.state == ST_SAMP_SIG) ||
                    (r_q.state == ST_ROW_RST)  || (r_q.state == ST_SAMP_RST);

    rowseq_row_decode #(.NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W)) u_rowdec (
        .en_i  (row_en),
        .row_i (r_q.row),
        .sel_o (row_sel_o)
    );

    assign samp_sig_o  = (r_q.state == ST_SAMP_SIG);
    assign plate_gnd_o = (r_q.state == ST_SAMP_SIG);
    assign row_rst_o   = (r_q.state == ST_ROW_RST);
    assign samp_rst_o  = (r_q.state == ST_SAMP_RST);
    assign rd_ph_a_o   = (r_q.state == ST_READ_A);
    assign rd_ph_b_o   = (r_q.state == ST_READ_B);
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
endmodule

// File: rtl/rowseq_chk.sv
module rowseq_chk #(
    parameter int NUM_ROWS = 16,
    parameter int NUM_COLS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_ROWS-1:0] row_sel_o,
    input logic                row_rst_o,
    input logic                samp_sig_o,
    input logic                samp_rst_o,
    input logic                plate_gnd_o,
    input logic [NUM_COLS-1:0] col_strb_o,
    input logic                rd_ph_a_o,
    input logic                rd_ph_b_o,
    input logic                busy_o,
    input logic                done_o
);
    AST_ROWSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_sel_o)); // R3
    AST_ROWSEL_COVERS_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_sig_o || row_rst_o || samp_rst_o) |-> (row_sel_o != '0)); // R3
    AST_ROWSEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((row_sel_o != '0) && ($past(row_sel_o) != '0)) |-> $stable(row_sel_o)); // R7
    AST_RESET_AFTER_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_rst_o) |-> $past(samp_sig_o)); // R2
    AST_REFSAMPLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_rst_o) |-> $past(row_rst_o)); // R2
    AST_PLATE_FLOATS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        row_rst_o |-> !plate_gnd_o); // R4
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_strb_o)); // R5
    AST_COL_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ph_a_o || rd_ph_b_o) |-> (col_strb_o != '0)); // R5
    AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_ph_a_o) && $past(rd_ph_b_o)) |-> (col_strb_o == ($past(col_strb_o) << 1))); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rd_ph_b_o) && !busy_o)); // R6
endmodule

bind rowseq_top rowseq_chk #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_sel_o   (row_sel_o),
    .row_rst_o   (row_rst_o),
    .samp_sig_o  (samp_sig_o),
    .samp_rst_o  (samp_rst_o),
    .plate_gnd_o (plate_gnd_o),
    .col_strb_o  (col_strb_o),
    .rd_ph_a_o   (rd_ph_a_o),
    .rd_ph_b_o   (rd_ph_b_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/rowseq_top_tb.sv
module rowseq_top_tb;
    localparam int NR = 16;
    localparam int NC = 16;
    localparam int NV = 7;
    // Vector: {row[12:9], col_count[8:4], phase_len[3:0]}
    localparam logic [12:0] VEC [NV] = '{
        {4'd0,  5'd1,  4'd1},
        {4'd5,  5'd4,  4'd2},
        {4'd15, 5'd16, 4'd1},
        {4'd9,  5'd3,  4'd3},
        {4'd3,  5'd0,  4'd2},
        {4'd12, 5'd31, 4'd1},
        {4'd7,  5'd2,  4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [3:0]    row_idx_i = '0;
    logic [4:0]    col_count_i = '0;
    logic [3:0]    phase_len_i = '0;
    logic [NR-1:0] row_sel_o;
    logic          row_rst_o, samp_sig_o, samp_rst_o, plate_gnd_o;
    logic [NC-1:0] col_strb_o;
    logic          rd_ph_a_o, rd_ph_b_o, busy_o, done_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    rowseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .row_idx_i(row_idx_i),
        .col_count_i(col_count_i), .phase_len_i(phase_len_i),
        .row_sel_o(row_sel_o), .row_rst_o(row_rst_o), .samp_sig_o(samp_sig_o),
        .samp_rst_o(samp_rst_o), .plate_gnd_o(plate_gnd_o), .col_strb_o(col_strb_o),
        .rd_ph_a_o(rd_ph_a_o), .rd_ph_b_o(rd_ph_b_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [39:0] outs();
        return {row_sel_o, row_rst_o, samp_sig_o, samp_rst_o, plate_gnd_o,
                col_strb_o, rd_ph_a_o, rd_ph_b_o, busy_o, done_o};
    endfunction

    // Expected outputs t cycles after the start is sampled.
    function automatic logic [39:0] exp_at(int row, int n, int len, int t);
        logic [NR-1:0] rs;
        logic [NC-1:0] cs;
        logic rr, ss, sr, pg, pa, pb, bz, dn;
        int u;
        rs = '0; cs = '0;
        {rr, ss, sr, pg, pa, pb, bz, dn} = '0;
        if (t < 4*len) begin
            rs[row] = 1'b1; bz = 1'b1;
            case (t / len)
                1: begin ss = 1'b1; pg = 1'b1; end
                2: rr = 1'b1;
                3: sr = 1'b1;
                default: ;
            endcase
        end else if (t < 4*len + 2*len*n) begin
            u = t - 4*len;
            cs[u / (2*len)] = 1'b1; bz = 1'b1;
            if ((u % (2*len)) < len) pa = 1'b1;
            else                      pb = 1'b1;
        end else if (t == 4*len + 2*len*n) begin
            dn = 1'b1;
        end
        return {rs, rr, ss, sr, pg, cs, pa, pb, bz, dn};
    endfunction

    task automatic check(string req, logic [39:0] got, logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic run_seq(int row, int ncr, int lr, bit inj);
        int n, len, total;
        bit clamped;
        string req;
        n = (ncr == 0) ? 1 : ((ncr > NC) ? NC : ncr);
        len = (lr == 0) ? 1 : lr;
        clamped = (ncr == 0) || (ncr > NC) || (lr == 0);
        total = 4*len + 2*len*n;
        @(negedge clk);
        row_idx_i = 4'(row); col_count_i = 5'(ncr); phase_len_i = 4'(lr);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t <= total + 3; t++) begin
            if (inj && (t == 2 || t == 4*len + 1)) begin
                start_i = 1'b1; row_idx_i = 4'(row ^ 1); col_count_i = 5'd1; phase_len_i = 4'd1;
            end else begin
                start_i = 1'b0;
            end
            if (inj)                        req = "R7";
            else if (clamped)               req = "R8";
            else if (t < 4*len)             req = "R2_R3_R4";
            else if (t < total)             req = "R5";
            else if (t == total)            req = "R6";
            else                            req = "R6_idle";
            check(req, outs(), exp_at(row, n, len, t));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), '0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1 idle after reset", outs(), '0);
        end

        for (int i = 0; i < NV; i++) begin
            run_seq(int'(VEC[i][12:9]), int'(VEC[i][8:4]), int'(VEC[i][3:0]), 1'b0);
        end

        // R7: start and input changes while busy are ignored
        run_seq(10, 3, 2, 1'b1);

        // R9: reset during the column scan
        @(negedge clk);
        row_idx_i = 4'd2; col_count_i = 5'd8; phase_len_i = 4'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 mid-scan before reset", {outs()[39:24], outs()[19:0] != 20'd0}, {16'd0, 1'b1});
        rst_n = 1'b0;
        #1;
        check("R9 outputs idle in reset", outs(), '0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check("R9 idle after reset", outs(), '0);
        end
        run_seq(1, 2, 1, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule